// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator

This block compares two 8-bit words, P and Q, and reports the result on two decision outputs: one for P greater than Q and one for P less than Q. A mode input chooses the number format at run time. With the mode low the words are compared as unsigned binary. With the mode high they are compared as two's complement.

The P operand first passes through a level-sensitive latch. The latch is transparent while its enable is high and holds its value while the enable is low. Reset clears the latch to zero. Q is not latched and goes straight to the compare.

Two cascade inputs carry the decision of a less-significant stage. When the two words are equal, each output copies its cascade input. Longer words are compared by wiring the outputs of each stage to the cascade inputs of the next more-significant stage. In a signed chain, only the top stage runs in arithmetic mode. The compare path is purely combinational, and the latch is the only state in the block.

Top module: `magcmp_cascade`

## Requirements
- R1: With `arith_i`=0 and the words unequal, `gt_o`=1 exactly when the held P is greater than `q_i` as unsigned, and `lt_o`=1 exactly when it is smaller.
- R2: With `arith_i`=1 and the words unequal, the words are compared as two's complement, with bit 7 as the sign bit. For example, 0x80 is less than 0x7F and 0xFF is less than 0x00.
- R3: While `le_i`=1, the latch is transparent: a change on `p_i` changes the outputs with no clock.
- R4: While `le_i`=0, the latch holds the value P had when `le_i` fell, and changes on `p_i` have no effect on the outputs.
- R5: While `rst_ni`=0, the held P is zero whatever `le_i` is. After `rst_ni` rises with `le_i`=0, the held P stays zero.
- R6: When the held P equals `q_i`, `gt_o` equals `gt_i` and `lt_o` equals `lt_i`, in all four combinations, including both low and both high.
- R7: When the held P differs from `q_i`, the cascade inputs are ignored and exactly one of `gt_o` and `lt_o` is 1.
- R8: `q_i` is never latched: while `le_i`=0, a change on `q_i` changes the outputs.
- R9: In a chain of two stages, the low stage uses `arith_i`=0 with its cascade inputs tied low, and its outputs feed the high stage. The high stage's `arith_i` then selects a correct 16-bit unsigned or signed compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Active-low asynchronous clear of the P latch |
| le_i | input | 1 | P latch enable: 1 means transparent, 0 means hold |
| arith_i | input | 1 | Compare mode: 0 is unsigned, 1 is two's complement |
| p_i | input | 8 | P operand, goes through the latch |
| q_i | input | 8 | Q operand, compared directly |
| gt_i | input | 1 | Cascade input: less-significant stage found P > Q |
| lt_i | input | 1 | Cascade input: less-significant stage found P < Q |
| gt_o | output | 1 | Decision output: P greater than Q |
| lt_o | output | 1 | Decision output: P less than Q |

## Verification
The latch is the only state in the block. A wrong held value shows at the outputs as soon as Q is moved near the value that should be held. Equality then either passes the cascade inputs through or fails to. The hold tests first fix P, then change `p_i` and `q_i` separately while the enable is low, and read the outputs after the inputs settle. This exposes a latch that is still transparent, or one that does not clear, in the same step as the stimulus. A sign-handling fault shows only where the top bits of the two words differ, so the corner words 0x00, 0x7F, 0x80 and 0xFF are crossed in both modes. A 16-bit chain also exposes a stage that fails to pass the lower decision through on equality.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned WORD_W = 8;

  typedef enum logic {
    MODE_LOGIC = 1'b0,
    MODE_ARITH = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/p_latch.sv
module p_latch #(
  parameter int unsigned W = cmp_pkg::WORD_W
) (
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_latch begin
    if (!rst_ni)   q_o = '0;
    else if (le_i) q_o = d_i;
  end

  // R5: reset clears the latch regardless of the enable
  always_comb begin
    if (!rst_ni) a_r5_clear: assert (q_o == '0) else $error("latch not cleared");
  end
endmodule

// File: rtl/word_compare.sv
module word_compare #(
  parameter int unsigned W = cmp_pkg::WORD_W
) (
  input  logic         arith_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o,
  output logic         lt_o,
  output logic         eq_o
);
  logic [W-1:0] a_m, b_m;
  logic [W:0]   eq_hi;
  logic [W-1:0] gt_bit, lt_bit;

  // signed compare = unsigned compare with sign bits inverted
  assign a_m = {a_i[W-1] ^ arith_i, a_i[W-2:0]};
  assign b_m = {b_i[W-1] ^ arith_i, b_i[W-2:0]};

  assign eq_hi[W] = 1'b1;
  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign eq_hi[i]  = eq_hi[i+1] & (a_m[i] ~^ b_m[i]);
    assign gt_bit[i] = eq_hi[i+1] & a_m[i] & ~b_m[i];
    assign lt_bit[i] = eq_hi[i+1] & ~a_m[i] & b_m[i];
  end

  assign gt_o = |gt_bit;
  assign lt_o = |lt_bit;
  assign eq_o = eq_hi[0];

  always_comb begin
    if (arith_i == cmp_pkg::MODE_LOGIC) begin
      a_r1_unsigned: assert (gt_o == (a_i > b_i) && lt_o == (a_i < b_i))
        else $error("unsigned compare wrong");
    end else begin
      a_r2_signed: assert (gt_o == ($signed(a_i) > $signed(b_i)) &&
                           lt_o == ($signed(a_i) < $signed(b_i)))
        else $error("signed compare wrong");
    end
  end
endmodule

// File: rtl/cascade_merge.sv
module cascade_merge (
  input  logic gt_i,
  input  logic lt_i,
  input  logic eq_i,
  input  logic cin_gt_i,
  input  logic cin_lt_i,
  output logic gt_o,
  output logic lt_o
);
  assign gt_o = eq_i ? cin_gt_i : gt_i;
  assign lt_o = eq_i ? cin_lt_i : lt_i;

  // R7: an unequal local decision is one-hot whatever the cascade inputs are
  always_comb begin
    if (!eq_i) a_r7_onehot: assert (gt_o ^ lt_o) else $error("decision not one-hot");
  end
endmodule

// File: rtl/magcmp_cascade.sv
module magcmp_cascade
  import cmp_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic         arith_i,
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] q_i,
  input  logic         gt_i,
  input  logic         lt_i,
  output logic         gt_o,
  output logic         lt_o
);
  logic [W-1:0] p_held;
  logic         loc_gt, loc_lt, loc_eq;

  p_latch #(.W(W)) u_latch (
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .d_i    (p_i),
    .q_o    (p_held)
  );

  word_compare #(.W(W)) u_cmp (
    .arith_i (arith_i),
    .a_i     (p_held),
    .b_i     (q_i),
    .gt_o    (loc_gt),
    .lt_o    (loc_lt),
    .eq_o    (loc_eq)
  );

  cascade_merge u_merge (
    .gt_i     (loc_gt),
    .lt_i     (loc_lt),
    .eq_i     (loc_eq),
    .cin_gt_i (gt_i),
    .cin_lt_i (lt_i),
    .gt_o     (gt_o),
    .lt_o     (lt_o)
  );

  always_comb begin
    if (p_held == q_i)
      a_r6_pass: assert (gt_o == gt_i && lt_o == lt_i) else $error("cascade not passed");
    if (le_i && rst_ni)
      a_r3_transparent: assert (p_held == p_i) else $error("latch not transparent");
  end
endmodule

// File: tb/tb_magcmp_cascade.sv
module tb_magcmp_cascade;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic         rst_ni, le_i, arith_i, gt_i, lt_i, gt_o, lt_o;
  logic [W-1:0] p_i, q_i;

  magcmp_cascade dut (
    .rst_ni(rst_ni), .le_i(le_i), .arith_i(arith_i), .p_i(p_i), .q_i(q_i),
    .gt_i(gt_i), .lt_i(lt_i), .gt_o(gt_o), .lt_o(lt_o)
  );

  // 16-bit chain
  logic         c_arith, c_mid_gt, c_mid_lt, c_gt, c_lt;
  logic [15:0]  c_p, c_q;

  magcmp_cascade chain_lo (
    .rst_ni(rst_ni), .le_i(1'b1), .arith_i(1'b0), .p_i(c_p[7:0]), .q_i(c_q[7:0]),
    .gt_i(1'b0), .lt_i(1'b0), .gt_o(c_mid_gt), .lt_o(c_mid_lt)
  );
  magcmp_cascade chain_hi (
    .rst_ni(rst_ni), .le_i(1'b1), .arith_i(c_arith), .p_i(c_p[15:8]), .q_i(c_q[15:8]),
    .gt_i(c_mid_gt), .lt_i(c_mid_lt), .gt_o(c_gt), .lt_o(c_lt)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {arith, p, q, cin_gt, cin_lt, exp_gt, exp_lt}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h7F, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'h7F, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'h80, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h80, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'h55, 8'h55, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'h3C, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1},
    {1'b0, 8'h01, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'hFE, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'h80, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic g, input logic l,
                       input logic eg, input logic el);
    checks++;
    if (g !== eg || l !== el) begin
      fails++;
      $display("FAIL %s: got gt=%b lt=%b expected gt=%b lt=%b", req, g, l, eg, el);
    end
  endtask

  task automatic settle();
    #(CLK_PERIOD / 2);
  endtask

  function automatic logic [1:0] ref_cmp(input logic ar, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic cg, input logic cl);
    if (a == b) return {cg, cl};
    if (ar) return {$signed(a) > $signed(b), $signed(a) < $signed(b)};
    return {a > b, a < b};
  endfunction

  initial begin
    rst_ni = 1'b0; le_i = 1'b1; arith_i = 1'b0; p_i = 8'h5A; q_i = 8'h00;
    gt_i = 1'b1; lt_i = 1'b0;
    c_arith = 1'b0; c_p = '0; c_q = '0;
    settle();
    // R5: reset clears latch even with enable high; P=0 equals Q=0 -> cascade through
    check("R5 reset clear", gt_o, lt_o, 1'b1, 1'b0);
    q_i = 8'h01; gt_i = 1'b0; settle();
    check("R5 reset clear q=1", gt_o, lt_o, 1'b0, 1'b1);
    le_i = 1'b0; settle();
    rst_ni = 1'b1; settle();
    check("R5 held zero after release", gt_o, lt_o, 1'b0, 1'b1);
    le_i = 1'b1;

    // R1 R2 R6 R7 vector table
    for (int i = 0; i < NV; i++) begin
      {arith_i, p_i, q_i, gt_i, lt_i} = VEC[i][20:2];
      settle();
      check($sformatf("R1/R2/R6/R7 vec %0d", i), gt_o, lt_o, VEC[i][1], VEC[i][0]);
    end

    // R1 R2 random sweep, corner values mixed in
    for (int i = 0; i < 400; i++) begin
      logic [1:0] e;
      arith_i = i[0];
      p_i = (i % 7 == 0) ? 8'h80 : (i % 11 == 0) ? 8'h7F : 8'($urandom);
      q_i = (i % 5 == 0) ? 8'hFF : (i % 13 == 0) ? 8'h00 : 8'($urandom);
      if (i % 9 == 0) q_i = p_i;
      gt_i = i[1]; lt_i = i[2];
      e = ref_cmp(arith_i, p_i, q_i, gt_i, lt_i);
      settle();
      check(arith_i ? "R2 random" : "R1 random", gt_o, lt_o, e[1], e[0]);
    end

    // R3 transparent
    arith_i = 1'b0; gt_i = 1'b0; lt_i = 1'b0; le_i = 1'b1;
    p_i = 8'h10; q_i = 8'h50; settle();
    check("R3 transparent lt", gt_o, lt_o, 1'b0, 1'b1);
    p_i = 8'h60; settle();
    check("R3 transparent gt", gt_o, lt_o, 1'b1, 1'b0);

    // R4 hold
    p_i = 8'h40; settle();
    le_i = 1'b0; settle();
    p_i = 8'h10; q_i = 8'h20; settle();
    check("R4 hold ignores p", gt_o, lt_o, 1'b1, 1'b0);
    q_i = 8'h40; gt_i = 1'b1; lt_i = 1'b1; settle();
    check("R4 held value equals 0x40", gt_o, lt_o, 1'b1, 1'b1);
    // R8 Q not latched
    gt_i = 1'b0; lt_i = 1'b0;
    q_i = 8'h50; settle();
    check("R8 q direct", gt_o, lt_o, 1'b0, 1'b1);
    arith_i = 1'b1; q_i = 8'hC0; settle();
    check("R8 q direct signed", gt_o, lt_o, 1'b1, 1'b0);
    le_i = 1'b1; settle();
    check("R3 reopen to p=0x10", gt_o, lt_o, 1'b1, 1'b0);

    // R9 16-bit chain
    for (int i = 0; i < 300; i++) begin
      logic [1:0] e;
      c_arith = i[0];
      c_p = 16'($urandom);
      c_q = (i % 4 == 0) ? {c_p[15:8], 8'($urandom)} : 16'($urandom);
      if (i % 10 == 0) c_q = c_p;
      if (i % 15 == 0) begin c_p = 16'h8000; c_q = 16'h7FFF; end
      if (i % 15 == 1) begin c_p = 16'hFFFF; c_q = 16'h0000; end
      if (c_p == c_q) e = 2'b00;
      else if (c_arith) e = {$signed(c_p) > $signed(c_q), $signed(c_p) < $signed(c_q)};
      else e = {c_p > c_q, c_p < c_q};
      settle();
      check(c_arith ? "R9 chain signed" : "R9 chain unsigned", c_gt, c_lt, e[1], e[0]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule